// File: doc/BRIEF.md
# Linear Burst Address Sequencer

This block produces the internal access address for one port of a synchronous SRAM that supports short bursts. A command cycle with the advance input low captures the full external address, the requested burst length and the read/write type. Each following cycle with advance high produces the next beat. The two lowest address bits count upward and wrap inside their aligned group of four words. The upper bits stay fixed for the whole burst. The sequencer allows two, three or four beats. It marks the final beat. Once the limit is reached, any further advance cycle issues no access and raises an overrun pulse instead.

Every output is registered and changes one clock edge after the inputs are sampled. The memory array and the data paths downstream use the access address, the valid strobe and the carried write flag. A deselect cycle (enable low) ends any burst in progress. After a deselect, and after reset, advance cycles do nothing until a new command is loaded.

Top module: `bseq_top`

## Requirements
- R1: While reset is asserted, and on the first edge after reset is released with enable low, `acc_vld_o`, `acc_last_o` and `ovr_o` are 0 and no burst is active.
- R2: A cycle with `en_i`=1 and `adv_i`=0 loads a command. On the next edge `acc_vld_o`=1, `acc_addr_o` equals `addr_i` and `acc_wr_o` equals `cmd_write_i`.
- R3: Each accepted continuation beat (`en_i`=1, `adv_i`=1, burst active and below its limit) increments `acc_addr_o[1:0]` by one, modulo 4. The value 3 is followed by 0.
- R4: On continuation beats, `acc_addr_o[ADDR_W-1:2]` keeps the value captured at load.
- R5: `acc_wr_o` keeps the type captured at load for the whole burst. `cmd_write_i` has no effect on advance cycles.
- R6: `len_i` is sampled at load with this encoding: 0 = two beats, 1 = three beats, 2 or 3 = four beats. The load beat counts as the first beat. A burst delivers exactly that many valid beats.
- R7: `acc_last_o` is 1 exactly on the valid beat that reaches the burst length, and only together with `acc_vld_o`.
- R8: An advance cycle on an active burst that has already reached its limit issues no access (`acc_vld_o`=0). It raises `ovr_o` for that one cycle and leaves the address unchanged.
- R9: An advance cycle while no burst is active, after reset or after a deselect, issues no access and raises no overrun.
- R10: A cycle with `en_i`=0 issues no access, raises no overrun and ends any active burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Device enable for this cycle |
| adv_i | input | 1 | 0 loads a command, 1 advances the current burst |
| cmd_write_i | input | 1 | Command type on load, 1 = write |
| len_i | input | 2 | Burst length code, sampled on load |
| addr_i | input | ADDR_W | External address, sampled on load |
| acc_addr_o | output | ADDR_W | Registered access address |
| acc_vld_o | output | 1 | Access issued this cycle |
| acc_wr_o | output | 1 | Type of the current burst, 1 = write |
| acc_last_o | output | 1 | Current beat is the final one of the burst |
| ovr_o | output | 1 | Advance cycle past the burst limit was ignored |

## Verification
The assertions check on every cycle how each kind of input cycle maps to the registered outputs one edge later. A load must reproduce the sampled address and type. A continuation beat must step the low bits with wrap while the upper bits hold. A deselect must be silent, overrun and a valid beat never appear together, and the final-beat flag never appears without a valid beat. Some behaviour involves state kept across several cycles, and only the bench scenarios can show it. This covers the exact beat count for each length code, overrun repeating after the limit, idle advance cycles after reset and after a deselect, and the type carried through while `cmd_write_i` toggles.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Classification of one sampled input cycle
  typedef enum logic [2:0] {
    K_DESEL = 3'd0,  // enable low
    K_LOAD  = 3'd1,  // new command
    K_IDLE  = 3'd2,  // advance with no active burst
    K_OVER  = 3'd3,  // advance past the limit
    K_STEP  = 3'd4   // accepted continuation beat
  } cyc_kind_e;

  localparam int unsigned MAX_BEATS = 4;
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS + 1);
  localparam int unsigned LOW_W     = 2;

  // Length code to beat count: 0 -> 2, 1 -> 3, others -> 4
  function automatic logic [CNT_W-1:0] len_to_beats(input logic [1:0] code);
    logic [CNT_W-1:0] b;
    unique case (code)
      2'd0:    b = CNT_W'(2);
      2'd1:    b = CNT_W'(3);
      default: b = CNT_W'(MAX_BEATS);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic      en_i,
  input  logic      adv_i,
  input  logic      active_i,
  input  logic      at_limit_i,
  output cyc_kind_e kind_o
);

  always_comb begin
    if (!en_i)            kind_o = K_DESEL;
    else if (!adv_i)      kind_o = K_LOAD;
    else if (!active_i)   kind_o = K_IDLE;
    else if (at_limit_i)  kind_o = K_OVER;
    else                  kind_o = K_STEP;
  end

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cyc_kind_e kind_i,
  input  logic [1:0] len_i,
  input  logic      cmd_write_i,
  output logic      active_o,
  output logic      at_limit_o,
  output logic      wr_o,
  output logic      last_next_o
);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             wr_q,  wr_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    wr_d   = wr_q;
    cnt_en = 1'b0;
    unique case (kind_i)
      K_DESEL: begin
        act_d  = 1'b0;
        cnt_en = 1'b1;
      end
      K_LOAD: begin
        act_d  = 1'b1;
        cnt_d  = CNT_W'(1);
        lim_d  = len_to_beats(len_i);
        wr_d   = cmd_write_i;
        cnt_en = 1'b1;
      end
      K_STEP: begin
        cnt_d  = cnt_inc;
        cnt_en = 1'b1;
      end
      default: cnt_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      wr_q  <= 1'b0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      wr_q  <= wr_d;
    end
  end

  assign active_o    = act_q;
  assign at_limit_o  = (cnt_q >= lim_q);
  assign wr_o        = wr_q;
  assign last_next_o = (kind_i == K_STEP) && (cnt_inc == lim_q);

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned UP_W = ADDR_W - LOW_W;

  logic [LOW_W-1:0] low_q, low_d;
  logic             ld, step, low_en;

  assign ld     = (kind_i == K_LOAD);
  assign step   = (kind_i == K_STEP);
  assign low_en = ld | step;

  // Low bits wrap naturally at the group boundary
  always_comb begin
    if (ld) low_d = addr_i[LOW_W-1:0];
    else    low_d = low_q + LOW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (low_en) low_q <= low_d;
  end

  generate
    if (UP_W > 0) begin : g_upper
      logic [UP_W-1:0] up_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  up_q <= '0;
        else if (ld) up_q <= addr_i[ADDR_W-1:LOW_W];
      end
      assign addr_o = {up_q, low_q};
    end else begin : g_low_only
      assign addr_o = low_q;
    end
  endgenerate

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              cmd_write_i,
  input  logic [1:0]        len_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_vld_o,
  output logic              acc_wr_o,
  output logic              acc_last_o,
  output logic              ovr_o
);

  cyc_kind_e kind;
  logic      active, at_limit, last_next;
  logic      vld_d, ovr_d;

  bseq_decode u_dec (
    .en_i       (en_i),
    .adv_i      (adv_i),
    .active_i   (active),
    .at_limit_i (at_limit),
    .kind_o     (kind)
  );

  bseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind_i      (kind),
    .len_i       (len_i),
    .cmd_write_i (cmd_write_i),
    .active_o    (active),
    .at_limit_o  (at_limit),
    .wr_o        (acc_wr_o),
    .last_next_o (last_next)
  );

  bseq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind_i (kind),
    .addr_i (addr_i),
    .addr_o (acc_addr_o)
  );

  assign vld_d = (kind == K_LOAD) || (kind == K_STEP);
  assign ovr_d = (kind == K_OVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld_o  <= 1'b0;
      acc_last_o <= 1'b0;
      ovr_o      <= 1'b0;
    end else begin
      acc_vld_o  <= vld_d;
      acc_last_o <= last_next;
      ovr_o      <= ovr_d;
    end
  end

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              adv_i,
  input logic              cmd_write_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic              acc_vld_o,
  input logic              acc_wr_o,
  input logic              acc_last_o,
  input logic              ovr_o
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i && !adv_i) |-> (acc_vld_o && acc_addr_o == $past(addr_i)
                               && acc_wr_o == $past(cmd_write_i)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && $past(en_i && adv_i)) |->
      (acc_addr_o[1:0] == $past(acc_addr_o[1:0]) + 2'd1));

  assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && $past(en_i && adv_i)) |->
      (acc_addr_o[ADDR_W-1:2] == $past(acc_addr_o[ADDR_W-1:2])));

  assert_type_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i && adv_i) |-> $stable(acc_wr_o));

  assert_last_with_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last_o |-> acc_vld_o);

  assert_ovr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (!acc_vld_o && $past(en_i && adv_i) && $stable(acc_addr_o)));

  assert_desel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_i) |-> (!acc_vld_o && !ovr_o));

endmodule

bind bseq_top bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .adv_i       (adv_i),
  .cmd_write_i (cmd_write_i),
  .addr_i      (addr_i),
  .acc_addr_o  (acc_addr_o),
  .acc_vld_o   (acc_vld_o),
  .acc_wr_o    (acc_wr_o),
  .acc_last_o  (acc_last_o),
  .ovr_o       (ovr_o)
);

// File: tb/bseq_top_bench.sv
module bseq_top_bench;

  localparam int unsigned AW = 20;

  logic          clk;
  logic          rst_n;
  logic          en_i, adv_i, cmd_write_i;
  logic [1:0]    len_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] acc_addr_o;
  logic          acc_vld_o, acc_wr_o, acc_last_o, ovr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  bit          m_act;
  int          m_cnt, m_lim;
  logic [AW-1:0] e_addr;
  logic        e_vld, e_wr, e_last, e_ovr;
  string       e_tag;

  bseq_top #(.ADDR_W(AW)) u_bseq_top (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .adv_i(adv_i),
    .cmd_write_i(cmd_write_i), .len_i(len_i), .addr_i(addr_i),
    .acc_addr_o(acc_addr_o), .acc_vld_o(acc_vld_o), .acc_wr_o(acc_wr_o),
    .acc_last_o(acc_last_o), .ovr_o(ovr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int beats_of(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : 4;
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return {a[AW-1:2], a[1:0] + 2'd1};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk({e_tag, " vld"},  AW'(acc_vld_o),  AW'(e_vld));
    chk({e_tag, " ovr"},  AW'(ovr_o),      AW'(e_ovr));
    chk({e_tag, " last"}, AW'(acc_last_o), AW'(e_last));
    chk({e_tag, " addr"}, acc_addr_o,      e_addr);
    chk({e_tag, " wr"},   AW'(acc_wr_o),   AW'(e_wr));
  endtask

  // drive one cycle of inputs (at a negedge) and advance the model
  task automatic drive(input bit en, input bit adv, input bit cw,
                       input logic [1:0] len, input logic [AW-1:0] a);
    en_i = en; adv_i = adv; cmd_write_i = cw; len_i = len; addr_i = a;
    e_ovr = 1'b0; e_last = 1'b0;
    if (!en) begin
      m_act = 0; e_vld = 1'b0; e_tag = "R10 deselect";
    end else if (!adv) begin
      m_act = 1; m_cnt = 1; m_lim = beats_of(len);
      e_addr = a; e_wr = cw; e_vld = 1'b1; e_tag = "R2 load";
    end else if (!m_act) begin
      e_vld = 1'b0; e_tag = "R9 idle advance";
    end else if (m_cnt >= m_lim) begin
      e_vld = 1'b0; e_ovr = 1'b1; e_tag = "R8 overrun";
    end else begin
      m_cnt++;
      e_addr = step_addr(e_addr); e_vld = 1'b1;
      e_last = (m_cnt == m_lim);
      e_tag = e_last ? "R7 R6 final beat" : "R3 R4 R5 step";
    end
  endtask

  task automatic cyc(input bit en, input bit adv, input bit cw,
                     input logic [1:0] len, input logic [AW-1:0] a);
    @(negedge clk);
    check_outputs();
    drive(en, adv, cw, len, a);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0;
    en_i = 0; adv_i = 0; cmd_write_i = 0; len_i = 0; addr_i = '0;
    m_act = 0; m_cnt = 0; m_lim = 0;
    e_addr = '0; e_vld = 0; e_wr = 0; e_last = 0; e_ovr = 0;
    e_tag = "R1 reset";
    repeat (3) @(negedge clk);
    check_outputs();                     // R1 during reset
    rst_n = 1'b1;
    drive(0, 0, 0, 2'd0, '0);
    e_tag = "R1 after reset";

    // R9: advance after reset does nothing
    cyc(1, 1, 1, 2'd2, 20'h12345);
    cyc(1, 1, 0, 2'd2, 20'h12345);
    // R3 wrap, R6 four beats, R8 repeated overrun, R5 type held
    cyc(1, 0, 1, 2'd2, 20'hABCD2);
    cyc(1, 1, 0, 2'd0, 20'h00000);
    cyc(1, 1, 0, 2'd1, 20'hFFFFF);
    cyc(1, 1, 0, 2'd0, 20'h00000);
    cyc(1, 1, 1, 2'd0, 20'h00000);
    cyc(1, 1, 1, 2'd0, 20'h00000);
    // R6 three beats starting at 3
    cyc(1, 0, 0, 2'd1, 20'h55553);
    cyc(1, 1, 1, 2'd2, 20'h0);
    cyc(1, 1, 1, 2'd2, 20'h0);
    cyc(1, 1, 1, 2'd2, 20'h0);
    // R6 two beats, code 3 = four beats
    cyc(1, 0, 1, 2'd0, 20'h00001);
    cyc(1, 1, 0, 2'd0, 20'h0);
    cyc(1, 1, 0, 2'd0, 20'h0);
    cyc(1, 0, 0, 2'd3, 20'hFFFFF);
    cyc(1, 1, 0, 2'd3, 20'h0);
    // R10 deselect mid-burst, then R9 idle advance
    cyc(0, 1, 0, 2'd3, 20'h0);
    cyc(1, 1, 0, 2'd3, 20'h0);
    cyc(1, 1, 0, 2'd3, 20'h0);
    // back-to-back loads
    cyc(1, 0, 1, 2'd2, 20'h00010);
    cyc(1, 0, 0, 2'd2, 20'h00023);
    cyc(1, 1, 1, 2'd2, 20'h0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit en, adv;
      en  = ($urandom_range(0, 9) != 0);
      adv = ($urandom_range(0, 9) >= 3);
      cyc(en, adv, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
          AW'($urandom));
    end
    @(negedge clk);
    check_outputs();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule